// File: doc/BRIEF.md
# Programmable periodic interrupt generator

This block turns a 32.768 kHz time base into a programmable periodic event. A free-running phase counter advances once per 32 kHz enable pulse. A 4-bit rate code selects a power-of-two period. The block fires an event each time the counter reaches a whole multiple of that period. On each event it can pulse a periodic-flag set line and an interrupt-flag set line, for a separate status register to capture. It can also pulse a square-wave output.

The period, counted in 32 kHz enable pulses, is 2^(code-1). Code 0 stops the generator. Codes 1 and 2 would give very short periods, so they are remapped to 128 and 256 pulses. Events are aligned to the running count rather than to the moment the rate was written. After a rate change, the next event therefore falls on the next boundary of the new period. No extra event is produced.

The generator only fires while the periodic-interrupt enable or the square-wave enable is set. The phase counter keeps running in any case.

Top module: `periodic_irq_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are low at the next edge. The phase counter is held at 0 even if `tick32_en` is high. The first event after reset therefore comes after exactly one full period of enable pulses.
- R2: For rate codes 3 to 15, an event occurs on every 2^(code-1)-th `tick32_en` pulse.
- R3: Rate code 1 gives a period of 128 enable pulses. Rate code 2 gives a period of 256 enable pulses.
- R4: With rate code 0, no output pulses, whatever the enables are.
- R5: With `pie_en` and `sqw_en` both low, no output pulses. The phase counter still advances, so event alignment is kept when an enable returns.
- R6: An event occurs only on the enable pulse that takes the count of enable pulses since reset to a multiple of the selected period. After a rate change, the next event is on the next multiple of the new period. The change itself produces no event.
- R7: When an event occurs with `pie_en` high, `pf_set` and `irqf_set` are both high for one clock. That clock is the one following the edge that sampled the `tick32_en` pulse.
- R8: When an event occurs with `sqw_en` high, `sqw_pulse` is high for that same single clock. `pf_set` and `irqf_set` stay low if `pie_en` is low.
- R9: No output is ever high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick32_en | input | 1 | One-clock enable at the 32.768 kHz rate |
| rate_code | input | 4 | Rate select: 0 off, 1 and 2 remapped, else period 2^(code-1) |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| pf_set | output | 1 | One-clock request to set the periodic flag |
| irqf_set | output | 1 | One-clock request to set the interrupt flag |
| sqw_pulse | output | 1 | One-clock square-wave pulse per event |

## Verification
A phase counter that slips or misses one increment moves every later event by one enable pulse. This shows at the very next event, within one period. A wrong mask or remap changes the spacing between events at once. A missing alignment after a rate change shows at the first event following the change. Every expected event is queued with its exact clock number, so an early, late, extra or absent pulse is caught in the clock where it should or should not have appeared.

// File: rtl/pig_pkg.sv
package pig_pkg;

    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] rate_code_t;

    // Short codes are remapped to these slower codes
    localparam rate_code_t REMAP_CODE1 = 4'd8;
    localparam rate_code_t REMAP_CODE2 = 4'd9;

    typedef struct packed {
        logic       run;    // code is non-zero
        logic [3:0] shift;  // log2 of period
    } rate_cfg_t;

    typedef struct packed {
        logic pf;
        logic irqf;
        logic sqw;
    } pulse_t;

    function automatic rate_cfg_t decode_rate(input rate_code_t code);
        rate_cfg_t  cfg;
        rate_code_t eff;
        case (code)
            4'd1:    eff = REMAP_CODE1;
            4'd2:    eff = REMAP_CODE2;
            default: eff = code;
        endcase
        cfg.run   = (code != '0);
        cfg.shift = eff - 4'd1;
        return cfg;
    endfunction

endpackage

// File: rtl/pig_rate_dec.sv
module pig_rate_dec
    import pig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  rate_code_t       code,
    input  logic             pie_en,
    input  logic             sqw_en,
    output logic             run,
    output logic [CNT_W-1:0] mask
);
    rate_cfg_t cfg;

    always_comb begin
        cfg  = decode_rate(code);
        run  = cfg.run && (pie_en || sqw_en);
        mask = (CNT_W'(1) << cfg.shift) - CNT_W'(1);
    end

endmodule

// File: rtl/pig_phase_cnt.sv
module pig_phase_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             run,
    input  logic [CNT_W-1:0] mask,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt + CNT_W'(1);
        hit     = step_en && run && ((cnt_nxt & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step_en)
            cnt <= cnt_nxt;
    end

    // R2: counter advances by exactly one per enable pulse
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        step_en |=> cnt == $past(cnt) + CNT_W'(1));

    // R5: counter holds between enable pulses
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(cnt));

endmodule

// File: rtl/pig_pulse_out.sv
module pig_pulse_out
    import pig_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  logic   pie_en,
    input  logic   sqw_en,
    output pulse_t pulses
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulses <= '0;
        end else begin
            pulses.pf   <= hit && pie_en;
            pulses.irqf <= hit && pie_en;
            pulses.sqw  <= hit && sqw_en;
        end
    end

    // R7: flag pulses only follow an enabled event
    assert_pf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        pulses.pf |-> $past(pie_en) && $past(hit));

    assert_irqf_pair_R7: assert property (@(posedge clk) disable iff (rst)
        pulses.pf |-> pulses.irqf);

    // R8: square-wave pulse needs its enable
    assert_sqw_cause_R8: assert property (@(posedge clk) disable iff (rst)
        pulses.sqw |-> $past(sqw_en));

    // R9: single-cycle pulses
    assert_pf_single_R9: assert property (@(posedge clk) disable iff (rst)
        pulses.pf |=> !pulses.pf);

    assert_sqw_single_R9: assert property (@(posedge clk) disable iff (rst)
        pulses.sqw |=> !pulses.sqw);

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick32_en,
    input  logic [3:0] rate_code,
    input  logic       pie_en,
    input  logic       sqw_en,
    output logic       pf_set,
    output logic       irqf_set,
    output logic       sqw_pulse
);
    logic             run;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    pulse_t           pulses;

    pig_rate_dec #(.CNT_W(CNT_W)) u_dec (
        .code   (rate_code),
        .pie_en (pie_en),
        .sqw_en (sqw_en),
        .run    (run),
        .mask   (mask)
    );

    pig_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_en (tick32_en),
        .run     (run),
        .mask    (mask),
        .cnt     (cnt),
        .hit     (hit)
    );

    pig_pulse_out u_out (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .pie_en (pie_en),
        .sqw_en (sqw_en),
        .pulses (pulses)
    );

    assign pf_set    = pulses.pf;
    assign irqf_set  = pulses.irqf;
    assign sqw_pulse = pulses.sqw;

    // R4: code 0 never yields a pulse
    assert_code0_silent_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_code) == 4'd0) |-> !pf_set && !sqw_pulse);

    // R6: every pulse lands on a period boundary of the count
    assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (pf_set || sqw_pulse) |-> (cnt & $past(mask)) == '0);

    // R1: reset clears outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !pf_set && !irqf_set && !sqw_pulse);

endmodule

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick32_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       pf_set, irqf_set, sqw_pulse;

    always #4 clk = ~clk;   // 125 MHz

    periodic_irq_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .tick32_en (tick32_en),
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .sqw_en    (sqw_en),
        .pf_set    (pf_set),
        .irqf_set  (irqf_set),
        .sqw_pulse (sqw_pulse)
    );

    typedef struct {
        int         cyc;
        logic [2:0] v;   // {pf, irqf, sqw}
    } exp_t;

    exp_t  sb_q[$];
    int    total = 0;
    int    bad = 0;
    int    edge_no = 0;
    int    m_cnt = 0;      // model count of enable pulses since reset
    int    exp_events = 0;
    int    got_events = 0;
    string cur_req = "R1";
    bit    done = 0;

    always @(posedge clk) edge_no <= edge_no + 1;

    function automatic int model_period(input logic [3:0] c);
        int e;
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 1 << (e - 1);
    endfunction

    // Monitor: compare outputs against the scoreboard each clock
    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] exp_v;
            logic [2:0] act_v;
            exp_v = 3'b000;
            act_v = {pf_set, irqf_set, sqw_pulse};
            if (sb_q.size() > 0 && sb_q[0].cyc == edge_no) begin
                exp_v = sb_q[0].v;
                void'(sb_q.pop_front());
            end
            if (act_v != 3'b000) got_events++;
            if (exp_v != 3'b000 || act_v != 3'b000) begin
                total++;
                if (act_v != exp_v) begin
                    bad++;
                    $display("FAIL %s edge %0d: outputs actual=%b expected=%b",
                             cur_req, edge_no, act_v, exp_v);
                end
            end
        end
    end

    // Driver: one clock with the given inputs; pushes expected events
    task automatic step(input logic en);
        @(negedge clk);
        tick32_en = en;
        if (en && !rst) begin
            m_cnt++;
            if (rate_code != 0 && (pie_en || sqw_en) &&
                (m_cnt % model_period(rate_code)) == 0) begin
                exp_t it;
                it.cyc = edge_no + 1;
                it.v   = {pie_en, pie_en, sqw_en};
                sb_q.push_back(it);
                exp_events++;
            end
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_phase(input logic [3:0] code, input logic pie, input logic sqw,
                             input int nticks, input string req);
        @(negedge clk);
        rate_code = code; pie_en = pie; sqw_en = sqw; cur_req = req;
        exp_events = 0; got_events = 0;
        for (int i = 0; i < nticks; i++) begin
            step(1'b1);
            step(1'b0);
        end
        step(1'b0);
        step(1'b0);
        check_eq(req, got_events, exp_events);
        check_eq(req, sb_q.size(), 0);
    endtask

    task automatic main_seq();
        // R1: reset with enable pulses that must not advance the counter
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tick32_en = (i % 2 == 0);
            rate_code = 4'd3; pie_en = 1'b1;
        end
        @(negedge clk);
        tick32_en = 1'b0;
        rst = 1'b0;
        m_cnt = 0;
        @(negedge clk);
        check_eq("R1 pf", int'(pf_set), 0);
        check_eq("R1 irqf", int'(irqf_set), 0);
        check_eq("R1 sqw", int'(sqw_pulse), 0);
        // R1/R2: first event after exactly one period from reset
        run_phase(4'd3, 1'b1, 1'b0, 40, "R2 code3");
        run_phase(4'd6, 1'b0, 1'b1, 100, "R8 sqw only");
        run_phase(4'd3, 1'b1, 1'b1, 30, "R7 both");
        run_phase(4'd1, 1'b1, 1'b1, 300, "R3 code1");
        run_phase(4'd2, 1'b1, 1'b0, 600, "R3 code2");
        run_phase(4'd0, 1'b1, 1'b1, 200, "R4 code0");
        check_eq("R4 silent", got_events, 0);
        run_phase(4'd5, 1'b0, 1'b0, 100, "R5 disabled");
        check_eq("R5 silent", got_events, 0);
        run_phase(4'd4, 1'b1, 1'b0, 37, "R5 resume");
        // R6: switch rate mid-period
        run_phase(4'd9, 1'b1, 1'b0, 101, "R6 slow");
        run_phase(4'd4, 1'b1, 1'b1, 53, "R6 fast");
        run_phase(4'd7, 1'b0, 1'b1, 70, "R6 switch");
        run_phase(4'd15, 1'b1, 1'b1, 17000, "R2 code15");
        check_eq("R9 code15 count", got_events, exp_events);
    endtask

    initial begin
        fork
            begin
                main_seq();
                done = 1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule